// File: doc/BRIEF.md
# Byte-Wide Discrete I/O Port

This block is an eight-pin general-purpose port that sits on a simple register bus. Software sets each pin's direction through a direction register and its output level through a data register. The data register has no second copy: it answers at two byte offsets, so a write at either one lands in the same latch and a read at either one returns the same value.

A select vector from elsewhere in the chip gives each pin to discrete I/O (bit = 1) or to an alternate on-chip function (bit = 0). Direction and data take effect only on pins given to discrete I/O. Reads of the data register return the latched value for pins that are discrete outputs and the synchronised pad level for all other pins. The pad inputs go through a two-flop synchroniser before the read-back mux. Reads are combinational from the address. Writes take effect on the rising clock edge on which the write strobe is high.

Top module: `dio_port8`

## Requirements
- R1: While reset is low and after it is released, the direction register reads 0x00 and every bit of pad_oe_o is 0.
- R2: A write at offset 0x1D loads the direction register. A read at offset 0x1D returns the stored value. A 1 bit means output and a 0 bit means input.
- R3: pad_oe_o bit i is 1 exactly when direction bit i is 1 and select bit i is 1 (discrete I/O). Pins owned by the alternate function are never enabled.
- R4: Offsets 0x19 and 0x1B both reach one data latch. A write at either offset updates it, and reads at both offsets return identical values.
- R5: pad_o bit i carries latch bit i when pad_oe_o bit i is 1, and carries 0 otherwise.
- R6: A read at 0x19 or 0x1B returns latch bit i for a pin that is a discrete output. For every other pin it returns the synchronised pad level.
- R7: A change on pad_i appears in data reads after exactly two rising clock edges and not after one.
- R8: Reads at any offset other than 0x19, 0x1B and 0x1D return 0x00. Writes at those offsets change neither register.
- R9: A data write updates the latch even on pins that are inputs or alternate-owned. The value appears on the pin once that pin becomes a discrete output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 5 | Byte offset of the access |
| wr_i | input | 1 | Write strobe, sampled at the rising edge |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational from addr_i |
| gpio_sel_i | input | 8 | Per-pin select: 1 = discrete I/O, 0 = alternate function |
| pad_i | input | 8 | Pad input levels |
| pad_o | output | 8 | Pad output levels |
| pad_oe_o | output | 8 | Pad output enables |

## Verification
Register writes show on rdata_o, pad_o and pad_oe_o one edge after the strobe, so the bench samples at the falling edge that follows. Output enables also follow gpio_sel_i combinationally within the same cycle. A new pad level reaches the read path only after two rising edges. For that reason the random loop holds the pads steady for three cycles before it reads, and a directed case samples after one edge and again after two to pin the latency down. The latch has no reset, so the bench's model tracks which latch bits are known and masks unknown bits out of the comparison.

// File: rtl/dio_port8_pkg.sv
package dio_port8_pkg;
  localparam int unsigned PinW  = 8;
  localparam int unsigned AddrW = 5;
  localparam logic [AddrW-1:0] OffDatA = 5'h19;
  localparam logic [AddrW-1:0] OffDatB = 5'h1B;
  localparam logic [AddrW-1:0] OffDir  = 5'h1D;

  typedef enum logic [1:0] {SelNone, SelData, SelDir} reg_sel_e;

  function automatic reg_sel_e decode(input logic [AddrW-1:0] a);
    if (a == OffDatA || a == OffDatB) return SelData;
    if (a == OffDir) return SelDir;
    return SelNone;
  endfunction
endpackage

// File: rtl/dio_sync.sv
module dio_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/dio_regs.sv
module dio_regs
  import dio_port8_pkg::*;
#(
  parameter int unsigned WIDTH = PinW
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  reg_sel_e         sel_i,
  input  logic             wr_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] dir_o,
  output logic [WIDTH-1:0] latch_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dir_o <= '0;
    else if (wr_i && sel_i == SelDir) dir_o <= wdata_i;
  end

  // data latch deliberately has no reset
  always_ff @(posedge clk_i) begin
    if (wr_i && sel_i == SelData) latch_o <= wdata_i;
  end
endmodule

// File: rtl/dio_port8.sv
module dio_port8
  import dio_port8_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [AddrW-1:0] addr_i,
  input  logic             wr_i,
  input  logic [PinW-1:0]  wdata_i,
  output logic [PinW-1:0]  rdata_o,
  input  logic [PinW-1:0]  gpio_sel_i,
  input  logic [PinW-1:0]  pad_i,
  output logic [PinW-1:0]  pad_o,
  output logic [PinW-1:0]  pad_oe_o
);
  reg_sel_e        acc_sel;
  logic [PinW-1:0] dir_q, latch_q, pad_sync, drive_mask;

  assign acc_sel = decode(addr_i);

  dio_regs #(.WIDTH(PinW)) u_regs (
    .clk_i, .rst_ni, .sel_i(acc_sel), .wr_i, .wdata_i,
    .dir_o(dir_q), .latch_o(latch_q)
  );

  dio_sync #(.WIDTH(PinW), .STAGES(2)) u_sync (
    .clk_i, .rst_ni, .d_i(pad_i), .q_o(pad_sync)
  );

  assign drive_mask = dir_q & gpio_sel_i;
  assign pad_oe_o   = drive_mask;

  for (genvar i = 0; i < PinW; i++) begin : g_pin
    assign pad_o[i] = drive_mask[i] & latch_q[i];
  end

  always_comb begin
    unique case (acc_sel)
      SelData: rdata_o = (latch_q & drive_mask) | (pad_sync & ~drive_mask);
      SelDir:  rdata_o = dir_q;
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/dio_port8_chk.sv
module dio_port8_chk
  import dio_port8_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic [AddrW-1:0] addr_i,
  input logic             wr_i,
  input logic [PinW-1:0]  wdata_i,
  input logic [PinW-1:0]  rdata_o,
  input logic [PinW-1:0]  gpio_sel_i,
  input logic [PinW-1:0]  pad_i,
  input logic [PinW-1:0]  pad_o,
  input logic [PinW-1:0]  pad_oe_o
);
  logic [1:0] up_cnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) up_cnt <= '0;
    else if (up_cnt != 2'd3) up_cnt <= up_cnt + 2'd1;
  end

  AST_RESET_OE: assert property (@(posedge clk_i) !rst_ni |-> pad_oe_o == '0); // R1
  AST_DIR_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == OffDir) |=> pad_oe_o == ($past(wdata_i) & gpio_sel_i)); // R2
  AST_OE_ALT_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_oe_o & ~gpio_sel_i) == '0); // R3
  AST_DATA_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && (addr_i == OffDatA || addr_i == OffDatB)) |=>
      ((pad_o ^ $past(wdata_i)) & pad_oe_o) == '0); // R4
  AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i != OffDatA && addr_i != OffDatB && addr_i != OffDir) |-> rdata_o == '0); // R8
  AST_INPUT_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_cnt >= 2'd2 && (addr_i == OffDatA || addr_i == OffDatB)) |->
      ((rdata_o ^ $past(pad_i, 2)) & ~pad_oe_o) == '0); // R7
endmodule

bind dio_port8 dio_port8_chk u_chk (.*);

// File: tb/dio_port8_test.sv
module dio_port8_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 0, rst_n = 0, wr = 0;
  logic [4:0] addr = 5'h00;
  logic [7:0] wdata = 0, rdata, sel = 0, pad_in = 0, pad_out, pad_oe;
  int checks = 0, failures = 0;

  logic [7:0] m_dir = 0, m_lat = 0, m_known = 0;

  dio_port8 uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .wdata_i(wdata),
    .rdata_o(rdata), .gpio_sel_i(sel), .pad_i(pad_in), .pad_o(pad_out), .pad_oe_o(pad_oe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] exp_oe();
    return m_dir & sel;
  endfunction
  function automatic logic [7:0] exp_data();
    return (m_lat & exp_oe()) | (pad_in & ~exp_oe());
  endfunction
  function automatic logic [7:0] care_data();
    return ~(exp_oe() & ~m_known);
  endfunction

  task automatic check(input string req, input logic [7:0] act, exp, mask);
    checks++;
    if (((act ^ exp) & mask) !== 8'h00) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h mask=%02h", req, act, exp, mask);
    end
  endtask

  task automatic wr_reg(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1;
    @(negedge clk); wr = 0;
    if (a == 5'h1D) m_dir = d;
    else if (a == 5'h19 || a == 5'h1B) begin m_lat = d; m_known = 8'hFF; end
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] v);
    @(negedge clk); addr = a; #1 v = rdata;
  endtask

  task automatic full_check(input string tag);
    logic [7:0] v;
    rd(5'h1D, v); check({tag, " R2 dir"}, v, m_dir, 8'hFF);
    check({tag, " R3 oe"}, pad_oe, exp_oe(), 8'hFF);
    check({tag, " R5 pad_o"}, pad_out, m_lat & exp_oe(), care_data() | ~exp_oe());
    rd(5'h19, v); check({tag, " R6 rd19"}, v, exp_data(), care_data());
    rd(5'h1B, v); check({tag, " R4 rd1B"}, v, exp_data(), care_data());
  endtask

  initial begin
    #(CLK_PERIOD*100000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    check("R1 oe during reset", pad_oe, 8'h00, 8'hFF);
    rst_n = 1;
    @(negedge clk);
    sel = 8'hFF;
    rd(5'h1D, v); check("R1 dir after reset", v, 8'h00, 8'hFF);
    check("R1 oe after reset", pad_oe, 8'h00, 8'hFF);

    // R9: latch written while all pins are inputs, then turned to outputs
    wr_reg(5'h1B, 8'h3C);
    check("R9 no drive as input", pad_oe, 8'h00, 8'hFF);
    wr_reg(5'h1D, 8'hFF);
    check("R9 pad_o after dir", pad_out, 8'h3C, 8'hFF);
    full_check("alias");

    // R3/R5: alternate ownership masks enables and output
    sel = 8'h0F; #1;
    check("R3 alt pins no oe", pad_oe, 8'h0F, 8'hFF);
    check("R5 alt pins zero", pad_out, 8'h0C, 8'hFF);

    // R7: two-edge latency on an input pin
    wr_reg(5'h1D, 8'h00);
    pad_in = 8'h00; repeat (3) @(negedge clk);
    addr = 5'h19; pad_in = 8'hA5;
    @(negedge clk); #1 check("R7 one edge old", rdata, 8'h00, 8'hFF);
    @(negedge clk); #1 check("R7 two edges new", rdata, 8'hA5, 8'hFF);

    // R8: unmapped offsets
    sel = 8'hFF;
    wr_reg(5'h1D, 8'h5A);
    wr_reg(5'h19, 8'h96);
    wr_reg(5'h1A, 8'hFF); m_lat = 8'h96; m_dir = 8'h5A;
    wr_reg(5'h1C, 8'h00);
    rd(5'h1A, v); check("R8 unmapped read", v, 8'h00, 8'hFF);
    rd(5'h00, v); check("R8 unmapped read 0", v, 8'h00, 8'hFF);
    repeat (2) @(negedge clk);
    full_check("R8 unchanged");

    for (int it = 0; it < 300; it++) begin
      int op;
      logic [4:0] a;
      logic [7:0] d;
      op = $urandom_range(0, 3);
      d  = 8'($urandom);
      case (op)
        0: a = 5'h19;
        1: a = 5'h1B;
        2: a = 5'h1D;
        default: begin
          a = 5'($urandom);
          if (a == 5'h19 || a == 5'h1B || a == 5'h1D) a = 5'h1E;
        end
      endcase
      @(negedge clk);
      sel = 8'($urandom); pad_in = 8'($urandom);
      if (op == 3) begin
        logic [7:0] sd, sl;
        sd = m_dir; sl = m_lat;
        wr_reg(a, d); m_dir = sd; m_lat = sl;
        rd(a, v); check("R8 random unmapped", v, 8'h00, 8'hFF);
      end else wr_reg(a, d);
      repeat (2) @(negedge clk);
      full_check("rand");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule